// File: doc/BRIEF.md
# SDRAM Command Turnaround Timing Checker

This block sits beside a DDR3-style memory controller and watches its command stream, one command per controller clock. Each command is an activate, read, write, precharge or idle slot, with a bank number and a burst-chop select bit. The block judges every command against the minimum spacing rules implied by earlier commands and the programmed latencies. A command that comes too early raises a violation flag in the same cycle, together with an error code that names the rule it broke. The block also reports the read and write latencies it derives from the programmed CAS latency, CAS write latency and additive latency.

The block keeps the open or closed state of each bank's row. It also keeps a set of down-counting gap timers: some are shared by all banks (column-to-column, read-to-write, write-to-read) and some belong to each bank (write recovery, read-to-precharge, active time, precharge time). The minimum read-to-write gap is derived from the latencies and from the length of the read burst. That length is either eight beats or a four-beat chop, fixed by mode or chosen on the fly per command. A command that violates a rule still takes effect, so later checks see the command stream as it was really issued.

Top module: `ddr_turn_chk`

## Requirements
- R1: `rl_o` equals `al_i + cl_i` and `wl_o` equals `al_i + cwl_i`, combinationally.
- R2: A gap is the number of clocks between two command cycles; the next cycle is gap 1. Command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4, and the other codes act as NOP. A NOP never flags. `viol_o` is high exactly when `err_code_o` is nonzero, and both are combinational from the current command.
- R3: A READ or WRITE to a bank whose row is closed gives code 1. Rows are closed at reset. ACT opens the row of its bank and PRE closes it.
- R4: A READ or WRITE at a gap below 4 after any READ or WRITE gives code 2, when no other rule applies.
- R5: A WRITE after a READ at a gap below max(4, RL+6-WL) gives code 3 when that read was eight beats long. The limit is max(4, RL+4-WL) when the read was chopped to four beats.
- R6: Burst mode `burst_mode_i` is 0 for fixed eight beats, 1 for on-the-fly and 2 for fixed four-beat chop; 3 behaves as 0. In on-the-fly mode, `chop_n_i`=1 selects eight beats and 0 selects a chop.
- R7: A READ after a WRITE at a gap below WL+D+T_WTR gives code 4. D is 2 when the write was issued in fixed-chop mode, and 4 otherwise.
- R8: A PRE to a bank after a WRITE to that bank at a gap below WL+D+T_WR gives code 5, with D as in R7.
- R9: A PRE to a bank after a READ to that bank at a gap below AL+T_RTP gives code 6.
- R10: A PRE to a bank after an ACT to that bank at a gap below T_RAS gives code 7.
- R11: An ACT to a bank after a PRE to that bank at a gap below T_RP gives code 8.
- R12: Priority is code 1 over 3/4 over 2 for READ and WRITE, and 5 over 6 over 7 for PRE. Every command that violates a rule still updates the bank state and starts its timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command code for this cycle |
| bank_i | input | BANK_W | Target bank |
| chop_n_i | input | 1 | On-the-fly length select, 1 = eight beats |
| cl_i | input | LAT_W | CAS read latency in clocks |
| cwl_i | input | LAT_W | CAS write latency in clocks |
| al_i | input | LAT_W | Additive latency in clocks |
| burst_mode_i | input | 2 | Burst mode select |
| viol_o | output | 1 | Current command breaks a rule |
| err_code_o | output | 4 | Code of the rule broken, 0 if none |
| rl_o | output | LAT_W+1 | Read latency |
| wl_o | output | LAT_W+1 | Write latency |

## Verification
Every gap timer in this block shows up at the ports only through the accept-or-flag decision on a later command. So a timer that was loaded wrong, that decays too fast, or that belongs to the wrong bank shows up as a flag at the wrong gap, or as the wrong code, on the first command that tests that rule. The bench sweeps the gap across each rule's threshold, one clock at a time, under several latency settings and all burst modes. An off-by-one in any timer then moves the threshold by one gap and fails at once. A wrong row state shows up as a spurious or missing code 1 on the next READ or WRITE to that bank.

// File: rtl/ddr_turn_pkg.sv
package ddr_turn_pkg;
  localparam int TCCD = 4;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_BL8 = 2'd0,
    MODE_OTF = 2'd1,
    MODE_BC4 = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    ERR_NONE   = 4'd0,
    ERR_NO_ROW = 4'd1,
    ERR_CCD    = 4'd2,
    ERR_RTW    = 4'd3,
    ERR_WTR    = 4'd4,
    ERR_WR     = 4'd5,
    ERR_RTP    = 4'd6,
    ERR_RAS    = 4'd7,
    ERR_RP     = 4'd8
  } err_e;
endpackage

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q, dec;

  assign dec    = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
  assign busy_o = (cnt_q != '0);

  // keep the later of the running and the new deadline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i && val_i > dec) cnt_q <= val_i;
    else                            cnt_q <= dec;
  end

  a_r4_timer_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && val_i != '0 |=> busy_o);

  a_r4_timer_decay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && busy_o |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/ddr_turn_lat.sv
module ddr_turn_lat
  import ddr_turn_pkg::*;
#(
  parameter int LAT_W = 5,
  parameter int CNT_W = 7,
  parameter int T_WTR = 4,
  parameter int T_WR  = 8,
  parameter int T_RTP = 4
) (
  input  logic [LAT_W-1:0] cl_i,
  input  logic [LAT_W-1:0] cwl_i,
  input  logic [LAT_W-1:0] al_i,
  input  logic [1:0]       mode_i,
  input  logic             chop_n_i,
  output logic [LAT_W:0]   rl_o,
  output logic [LAT_W:0]   wl_o,
  output logic [CNT_W-1:0] rtw_ld_o,
  output logic [CNT_W-1:0] wtr_ld_o,
  output logic [CNT_W-1:0] wr_ld_o,
  output logic [CNT_W-1:0] rtp_ld_o
);
  function automatic logic [CNT_W-1:0] to_ld(input int gap);
    return (gap > 0) ? CNT_W'(gap - 1) : '0;
  endfunction

  int  rl_n, wl_n, tail_n, rtw_n;
  logic full_burst;

  always_comb begin
    rl_n = int'(al_i) + int'(cl_i);
    wl_n = int'(al_i) + int'(cwl_i);
    case (mode_i)
      MODE_OTF: full_burst = chop_n_i;
      MODE_BC4: full_burst = 1'b0;
      default:  full_burst = 1'b1;
    endcase
    // write data end moves in only for fixed chop
    tail_n = (mode_i == MODE_BC4) ? 2 : 4;
    rtw_n  = rl_n + (full_burst ? TCCD + 2 : TCCD / 2 + 2) - wl_n;
    if (rtw_n < TCCD) rtw_n = TCCD;
  end

  assign rl_o     = (LAT_W+1)'(rl_n);
  assign wl_o     = (LAT_W+1)'(wl_n);
  assign rtw_ld_o = to_ld(rtw_n);
  assign wtr_ld_o = to_ld(wl_n + tail_n + T_WTR);
  assign wr_ld_o  = to_ld(wl_n + tail_n + T_WR);
  assign rtp_ld_o = to_ld(int'(al_i) + T_RTP);
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_turn_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int CNT_W  = 7,
  parameter int T_RAS  = 15,
  parameter int T_RP   = 6,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CNT_W-1:0]  wr_ld_i,
  input  logic [CNT_W-1:0]  rtp_ld_i,
  output logic              open_o,
  output logic              wr_busy_o,
  output logic              rtp_busy_o,
  output logic              ras_busy_o,
  output logic              rp_busy_o
);
  localparam logic [CNT_W-1:0] RAS_LD = CNT_W'((T_RAS > 0) ? T_RAS - 1 : 0);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'((T_RP > 0) ? T_RP - 1 : 0);

  logic [BANKS-1:0] open_q, wr_b, rtp_b, ras_b, rp_b;
  logic is_act, is_rd, is_wr, is_pre;

  assign is_act = (cmd_i == CMD_ACT);
  assign is_rd  = (cmd_i == CMD_RD);
  assign is_wr  = (cmd_i == CMD_WR);
  assign is_pre = (cmd_i == CMD_PRE);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_i == BANK_W'(b));

    ddr_gap_timer #(.W(CNT_W)) u_wr (
      .clk_i, .rst_ni, .load_i(hit && is_wr), .val_i(wr_ld_i), .busy_o(wr_b[b]));
    ddr_gap_timer #(.W(CNT_W)) u_rtp (
      .clk_i, .rst_ni, .load_i(hit && is_rd), .val_i(rtp_ld_i), .busy_o(rtp_b[b]));
    ddr_gap_timer #(.W(CNT_W)) u_ras (
      .clk_i, .rst_ni, .load_i(hit && is_act), .val_i(RAS_LD), .busy_o(ras_b[b]));
    ddr_gap_timer #(.W(CNT_W)) u_rp (
      .clk_i, .rst_ni, .load_i(hit && is_pre), .val_i(RP_LD), .busy_o(rp_b[b]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              open_q[b] <= 1'b0;
      else if (hit && is_act)   open_q[b] <= 1'b1;
      else if (hit && is_pre)   open_q[b] <= 1'b0;
    end

    a_r3_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit && is_pre |=> !open_q[b]);
  end

  assign open_o     = open_q[bank_i];
  assign wr_busy_o  = wr_b[bank_i];
  assign rtp_busy_o = rtp_b[bank_i];
  assign ras_busy_o = ras_b[bank_i];
  assign rp_busy_o  = rp_b[bank_i];
endmodule

// File: rtl/ddr_turn_chk.sv
module ddr_turn_chk
  import ddr_turn_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int LAT_W  = 5,
  parameter int CNT_W  = 7,
  parameter int T_WTR  = 4,
  parameter int T_WR   = 8,
  parameter int T_RTP  = 4,
  parameter int T_RP   = 6,
  parameter int T_RAS  = 15,
  parameter int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              chop_n_i,
  input  logic [LAT_W-1:0]  cl_i,
  input  logic [LAT_W-1:0]  cwl_i,
  input  logic [LAT_W-1:0]  al_i,
  input  logic [1:0]        burst_mode_i,
  output logic              viol_o,
  output logic [3:0]        err_code_o,
  output logic [LAT_W:0]    rl_o,
  output logic [LAT_W:0]    wl_o
);
  localparam logic [CNT_W-1:0] CCD_LD = CNT_W'(TCCD - 1);

  logic [CNT_W-1:0] rtw_ld, wtr_ld, wr_ld, rtp_ld;
  logic ccd_busy, rtw_busy, wtr_busy;
  logic row_open, wr_busy, rtp_busy, ras_busy, rp_busy;
  logic is_rd, is_wr, is_col;
  err_e err;

  assign is_rd  = (cmd_i == CMD_RD);
  assign is_wr  = (cmd_i == CMD_WR);
  assign is_col = is_rd || is_wr;

  ddr_turn_lat #(
    .LAT_W(LAT_W), .CNT_W(CNT_W), .T_WTR(T_WTR), .T_WR(T_WR), .T_RTP(T_RTP)
  ) u_lat (
    .cl_i, .cwl_i, .al_i, .mode_i(burst_mode_i), .chop_n_i,
    .rl_o, .wl_o,
    .rtw_ld_o(rtw_ld), .wtr_ld_o(wtr_ld), .wr_ld_o(wr_ld), .rtp_ld_o(rtp_ld)
  );

  ddr_gap_timer #(.W(CNT_W)) u_ccd (
    .clk_i, .rst_ni, .load_i(is_col), .val_i(CCD_LD), .busy_o(ccd_busy));
  ddr_gap_timer #(.W(CNT_W)) u_rtw (
    .clk_i, .rst_ni, .load_i(is_rd), .val_i(rtw_ld), .busy_o(rtw_busy));
  ddr_gap_timer #(.W(CNT_W)) u_wtr (
    .clk_i, .rst_ni, .load_i(is_wr), .val_i(wtr_ld), .busy_o(wtr_busy));

  ddr_bank_track #(
    .BANKS(BANKS), .CNT_W(CNT_W), .T_RAS(T_RAS), .T_RP(T_RP), .BANK_W(BANK_W)
  ) u_banks (
    .clk_i, .rst_ni, .cmd_i, .bank_i, .wr_ld_i(wr_ld), .rtp_ld_i(rtp_ld),
    .open_o(row_open), .wr_busy_o(wr_busy), .rtp_busy_o(rtp_busy),
    .ras_busy_o(ras_busy), .rp_busy_o(rp_busy)
  );

  always_comb begin
    err = ERR_NONE;
    case (cmd_i)
      CMD_RD: begin
        if (!row_open)     err = ERR_NO_ROW;
        else if (wtr_busy) err = ERR_WTR;
        else if (ccd_busy) err = ERR_CCD;
      end
      CMD_WR: begin
        if (!row_open)     err = ERR_NO_ROW;
        else if (rtw_busy) err = ERR_RTW;
        else if (ccd_busy) err = ERR_CCD;
      end
      CMD_PRE: begin
        if (wr_busy)       err = ERR_WR;
        else if (rtp_busy) err = ERR_RTP;
        else if (ras_busy) err = ERR_RAS;
      end
      CMD_ACT: begin
        if (rp_busy)       err = ERR_RP;
      end
      default: ;
    endcase
  end

  assign err_code_o = err;
  assign viol_o     = (err != ERR_NONE);

  a_r2_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_NOP |-> !viol_o);

  a_r4_ccd_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |=> (!is_col || viol_o));

  a_r3_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_ACT |=>
      !(is_col && bank_i == $past(bank_i) && err_code_o == ERR_NO_ROW));

  if (T_RAS > 1) begin : g_ras_chk
    a_r10_ras_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i == CMD_ACT |=>
        (!(cmd_i == CMD_PRE && bank_i == $past(bank_i)) || viol_o));
  end

  if (T_RP > 1) begin : g_rp_chk
    a_r11_rp_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_i == CMD_PRE |=>
        (!(cmd_i == CMD_ACT && bank_i == $past(bank_i)) || err_code_o == ERR_RP));
  end
endmodule

// File: tb/ddr_turn_chk_tb_top.sv
`timescale 1ns/1ps
module ddr_turn_chk_tb_top;
  localparam int T_WTR = 4, T_WR = 8, T_RTP = 4, T_RP = 6, T_RAS = 15;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd = NOP, bank = '0;
  logic chop_n = 1'b1;
  logic [4:0] cl = 5'd5, cwl = 5'd5, al = 5'd0;
  logic [1:0] mode = 2'd0;
  logic viol;
  logic [3:0] err;
  logic [5:0] rl, wl;
  logic s_viol;
  logic [3:0] s_err;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  ddr_turn_chk #(.T_WTR(T_WTR), .T_WR(T_WR), .T_RTP(T_RTP), .T_RP(T_RP), .T_RAS(T_RAS))
  dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .bank_i(bank), .chop_n_i(chop_n),
    .cl_i(cl), .cwl_i(cwl), .al_i(al), .burst_mode_i(mode),
    .viol_o(viol), .err_code_o(err), .rl_o(rl), .wl_o(wl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // flag and code together: 16*viol + code
  task automatic chk_code(input string tag, input int exp);
    chk(tag, int'(s_viol) * 16 + int'(s_err), (exp != 0 ? 16 : 0) + exp);
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] b, input logic cn);
    @(negedge clk);
    cmd = c; bank = b; chop_n = cn;
    #1;
    s_viol = viol; s_err = err;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(NOP, 3'd0, 1'b1);
  endtask

  initial begin
    #900000;
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cl_t[3]  = '{5, 7, 5};
    int cwl_t[3] = '{5, 5, 7};
    int al_t[3]  = '{0, 2, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state, R2
    step(NOP, 3'd0, 1'b1);
    chk_code("R2 reset nop", 0);
    chk("R1 reset rl", int'(rl), 5);
    // R3 closed at reset, R12 violating read still recorded
    step(RD, 3'd5, 1'b1);
    chk_code("R3 read closed", 1);
    step(ACT, 3'd5, 1'b1);
    chk_code("R3 act", 0);
    step(WR, 3'd5, 1'b1);
    chk_code("R12 recorded read rtw", 3);
    nops(30);
    step(PRE, 3'd5, 1'b1);
    nops(30);
    step(WR, 3'd5, 1'b1);
    chk_code("R3 write after pre", 1);
    // R12 priorities
    nops(30);
    step(ACT, 3'd7, 1'b1);
    step(WR, 3'd7, 1'b1);
    step(PRE, 3'd7, 1'b1);
    chk_code("R12 wr over ras", 5);
    nops(30);
    step(ACT, 3'd0, 1'b1);
    step(WR, 3'd0, 1'b1);
    step(RD, 3'd6, 1'b1);
    chk_code("R12 no_row over wtr", 1);

    // R4 column spacing
    for (int g = 1; g <= 6; g++) begin
      nops(30);
      step(ACT, 3'd0, 1'b1); nops(1);
      step(RD, 3'd0, 1'b1); nops(g - 1);
      step(RD, 3'd0, 1'b1);
      chk_code($sformatf("R4 rd-rd g=%0d", g), g < 4 ? 2 : 0);
      nops(30);
      step(WR, 3'd0, 1'b1); nops(g - 1);
      step(WR, 3'd0, 1'b1);
      chk_code($sformatf("R4 wr-wr g=%0d", g), g < 4 ? 2 : 0);
    end

    // R10 and R11
    for (int g = 1; g <= T_RAS + 2; g++) begin
      nops(30);
      step(ACT, 3'd3, 1'b1); nops(g - 1);
      step(PRE, 3'd3, 1'b1);
      chk_code($sformatf("R10 g=%0d", g), g < T_RAS ? 7 : 0);
    end
    for (int g = 1; g <= T_RP + 2; g++) begin
      nops(30);
      step(PRE, 3'd4, 1'b1); nops(g - 1);
      step(ACT, 3'd4, 1'b1);
      chk_code($sformatf("R11 g=%0d", g), g < T_RP ? 8 : 0);
    end

    for (int c = 0; c < 3; c++) begin
      int rl_e, wl_e;
      cl = 5'(cl_t[c]); cwl = 5'(cwl_t[c]); al = 5'(al_t[c]);
      rl_e = cl_t[c] + al_t[c];
      wl_e = cwl_t[c] + al_t[c];
      nops(30);
      chk($sformatf("R1 rl cfg%0d", c), int'(rl), rl_e);
      chk($sformatf("R1 wl cfg%0d", c), int'(wl), wl_e);
      // R9 depends only on latency
      for (int g = 1; g <= al_t[c] + T_RTP + 2; g++) begin
        nops(30);
        step(ACT, 3'd2, 1'b1); nops(T_RAS);
        step(RD, 3'd2, 1'b1); nops(g - 1);
        step(PRE, 3'd2, 1'b1);
        chk_code($sformatf("R9 cfg%0d g=%0d", c, g), g < al_t[c] + T_RTP ? 6 : 0);
      end
      for (int v = 0; v < 4; v++) begin
        int md, cn, full, tail, rtw_min, wtr_min, wr_min;
        md = (v == 0) ? 0 : (v == 3) ? 2 : 1;
        cn = (v == 2) ? 0 : 1;
        full = (md == 2) ? 0 : (md == 1) ? cn : 1;  // R6
        tail = (md == 2) ? 2 : 4;
        rtw_min = rl_e + (full != 0 ? 6 : 4) - wl_e;
        if (rtw_min < 4) rtw_min = 4;
        wtr_min = wl_e + tail + T_WTR;
        wr_min  = wl_e + tail + T_WR;
        mode = 2'(md);
        for (int g = 1; g <= 10; g++) begin
          nops(30);
          step(ACT, 3'd0, 1'(cn)); nops(1);
          step(RD, 3'd0, 1'(cn)); nops(g - 1);
          step(WR, 3'd0, 1'(cn));
          chk_code($sformatf("R5 R6 cfg%0d v%0d g=%0d", c, v, g), g < rtw_min ? 3 : 0);
        end
        for (int g = 1; g <= wtr_min + 1; g++) begin
          nops(30);
          step(ACT, 3'd0, 1'(cn)); nops(1);
          step(WR, 3'd0, 1'(cn)); nops(g - 1);
          step(RD, 3'd0, 1'(cn));
          chk_code($sformatf("R7 cfg%0d v%0d g=%0d", c, v, g), g < wtr_min ? 4 : 0);
        end
        for (int g = 1; g <= wr_min + 1; g++) begin
          nops(30);
          step(ACT, 3'd1, 1'(cn)); nops(T_RAS);
          step(WR, 3'd1, 1'(cn)); nops(g - 1);
          step(PRE, 3'd1, 1'(cn));
          chk_code($sformatf("R8 cfg%0d v%0d g=%0d", c, v, g), g < wr_min ? 5 : 0);
        end
      end
    end

    step(3'd6, 3'd0, 1'b1);
    chk_code("R2 unused code as nop", 0);
    nops(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule